// File: doc/BRIEF.md
# Request-Priority Congestion Monitor

This block sits in front of a DRAM controller and watches the stream of requests arriving at it. Each request comes with a 4-bit priority. A request is classed as urgent when its priority is 8 or more. The monitor counts requests in fixed windows whose length is a power of two. When a window closes, it compares the number of urgent requests in it with a programmable threshold. The result drives a single registered `congested` flag.

Downstream, the priority mappers of every channel use this flag to switch over to their alternate, lower-priority tables. This lowers the average priority seen by the controller. The controller can then spend its effort on bandwidth instead of serving requests strictly by priority. The threshold is given as a count out of the window length, which is how a percentage of the window is expressed. Cycles without a request do not count toward the window.

The reset input is asserted asynchronously. Inside the block its release is synchronised to the clock.

Top module: `req_congestion_monitor`

## Requirements
- R1: A valid request is urgent when `req_prio` is 8 or greater. Priority 7 and below is not urgent.
- R2: A window holds exactly 2^k valid requests. k is `win_len_log2`, clamped to `MAX_WIN_LOG2` (6 by default). k = 0 makes every request a window of its own.
- R3: When a window closes, `congested` is set if the urgent count of that window is strictly greater than `thresh`. Otherwise it is cleared, including when the two are equal.
- R4: `congested` takes its new value on the clock edge that accepts the closing request, and it then holds until the next window closes.
- R5: A cycle with `req_valid` low advances neither the window position nor the urgent count, whatever `req_prio` carries.
- R6: The window length is taken from `win_len_log2` at the first request of a window, so changing it later has no effect on that window. `thresh` is taken at the closing request.
- R7: Asserting `rst_n` low clears `congested` at once and empties both counters. Requests are counted from the third clock edge after `rst_n` rises.
- R8: A threshold equal to or above the window length never sets `congested`. A threshold of 0 sets it as soon as a window holds one urgent request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_prio | input | 4 | Priority of the presented request |
| win_len_log2 | input | 3 | Window length as log2 of the request count |
| thresh | input | 7 | Urgent-request count that must be exceeded |
| congested | output | 1 | Registered congestion flag |

## Verification
An internal counter that drifts only becomes visible at the port when a window closes. A request or urgent count that is off by one shows up either as the flag moving one request early or late, or as a wrong flag value at the next close. A window can hold up to 64 requests, so the error can stay hidden for up to that many accepted requests. For this reason the bench checks the flag after every single request, not only at window ends. It also drives urgent priorities during idle cycles and changes the window length in the middle of a window, so that a miscounted window is seen within one window length.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef struct packed {
    logic valid;
    logic urgent;
  } req_tag_t;
endpackage

// File: rtl/cm_rst_sync.sv
module cm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/cm_classify.sv
module cm_classify #(
  parameter int PRIO_W   = 4,
  parameter int URGENT_MIN = 8
) (
  input  logic              req_valid,
  input  logic [PRIO_W-1:0] req_prio,
  output cm_pkg::req_tag_t  tag
);
  always_comb begin
    tag.valid  = req_valid;
    tag.urgent = req_valid && (req_prio >= PRIO_W'(URGENT_MIN));
  end
endmodule

// File: rtl/cm_window.sv
module cm_window #(
  parameter int MAX_WIN_LOG2 = 6,
  parameter int WL_W  = 3,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cm_pkg::req_tag_t tag,
  input  logic [WL_W-1:0]  win_len_log2,
  output logic             win_close,
  output logic [CNT_W:0]   urgent_total,
  output logic [CNT_W-1:0] req_cnt,
  output logic [CNT_W-1:0] urg_cnt
);
  logic [WL_W-1:0]  k_live, k_q, k_d, k_eff;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] req_cnt_d, urg_cnt_d;
  logic             first_req;
  logic             cnt_en;

  always_comb begin
    k_live    = (win_len_log2 > WL_W'(MAX_WIN_LOG2)) ? WL_W'(MAX_WIN_LOG2) : win_len_log2;
    first_req = (req_cnt == '0);
    k_eff     = first_req ? k_live : k_q;
    span      = (CNT_W+1)'(1) << k_eff;
    last_idx  = CNT_W'(span - (CNT_W+1)'(1));
    win_close = tag.valid && (req_cnt == last_idx);
    urgent_total = {1'b0, urg_cnt} + (CNT_W+1)'(tag.urgent);
    cnt_en    = tag.valid;
    k_d       = (tag.valid && first_req) ? k_live : k_q;
    if (win_close) begin
      req_cnt_d = '0;
      urg_cnt_d = '0;
    end else begin
      req_cnt_d = req_cnt + CNT_W'(1);
      urg_cnt_d = urg_cnt + CNT_W'(tag.urgent);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cnt <= '0;
      urg_cnt <= '0;
      k_q     <= '0;
    end else if (cnt_en) begin
      req_cnt <= req_cnt_d;
      urg_cnt <= urg_cnt_d;
      k_q     <= k_d;
    end
  end
endmodule

// File: rtl/cm_flag.sv
module cm_flag #(
  parameter int CNT_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           win_close,
  input  logic [CNT_W:0] urgent_total,
  input  logic [CNT_W:0] thresh,
  output logic           congested
);
  logic flag_d;

  always_comb begin
    flag_d = (urgent_total > thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         congested <= 1'b0;
    else if (win_close) congested <= flag_d;
  end
endmodule

// File: rtl/req_congestion_monitor.sv
module req_congestion_monitor #(
  parameter int PRIO_W       = 4,
  parameter int URGENT_MIN   = 8,
  parameter int MAX_WIN_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [$clog2(MAX_WIN_LOG2+1)-1:0] win_len_log2,
  input  logic [MAX_WIN_LOG2:0] thresh,
  output logic              congested
);
  localparam int WL_W  = $clog2(MAX_WIN_LOG2+1);
  localparam int CNT_W = MAX_WIN_LOG2;

  logic             rst_sync_n;
  cm_pkg::req_tag_t tag;
  logic             win_close;
  logic [CNT_W:0]   urgent_total;
  logic [CNT_W-1:0] req_cnt;
  logic [CNT_W-1:0] urg_cnt;

  cm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  cm_classify #(.PRIO_W(PRIO_W), .URGENT_MIN(URGENT_MIN)) u_cls (
    .req_valid (req_valid),
    .req_prio  (req_prio),
    .tag       (tag)
  );

  cm_window #(.MAX_WIN_LOG2(MAX_WIN_LOG2), .WL_W(WL_W), .CNT_W(CNT_W)) u_win (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tag          (tag),
    .win_len_log2 (win_len_log2),
    .win_close    (win_close),
    .urgent_total (urgent_total),
    .req_cnt      (req_cnt),
    .urg_cnt      (urg_cnt)
  );

  cm_flag #(.CNT_W(CNT_W)) u_flag (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .win_close    (win_close),
    .urgent_total (urgent_total),
    .thresh       (thresh),
    .congested    (congested)
  );
endmodule

// File: rtl/cm_checker.sv
module cm_checker #(
  parameter int PRIO_W = 4,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [PRIO_W-1:0] req_prio,
  input logic              win_close,
  input logic [CNT_W-1:0]  req_cnt,
  input logic [CNT_W-1:0]  urg_cnt,
  input logic              congested
);
  assert_urgent_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    urg_cnt <= req_cnt);

  assert_idle_no_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(req_cnt) && $stable(urg_cnt)));

  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_close |=> $stable(congested));

  assert_close_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> (req_cnt == '0 && urg_cnt == '0));

  assert_urgent_counted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_prio >= PRIO_W'(8) && !win_close) |=> (urg_cnt == $past(urg_cnt) + CNT_W'(1)));
endmodule

bind req_congestion_monitor cm_checker #(.PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_prio  (req_prio),
  .win_close (win_close),
  .req_cnt   (req_cnt),
  .urg_cnt   (urg_cnt),
  .congested (congested)
);

// File: tb/tb_req_congestion_monitor.sv
module tb_req_congestion_monitor;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_prio;
  logic [2:0] win_len_log2;
  logic [6:0] thresh;
  logic       congested;

  int  vectors;
  int  miscompares;
  logic exp_flag;
  bit  done;

  req_congestion_monitor dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_prio     (req_prio),
    .win_len_log2 (win_len_log2),
    .thresh       (thresh),
    .congested    (congested)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: congested=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] p);
    @(negedge clk);
    req_valid = v;
    req_prio  = p;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R7 async clear", congested, 1'b0);
    exp_flag = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Sends one full window. Urgent requests go first, and gap idle cycles
  // (with an urgent priority on the bus) precede every request.
  task automatic run_window(input string req, input int k, input int thr,
                            input int nurg, input int gap);
    int w;
    w = 1 << ((k > 6) ? 6 : k);
    win_len_log2 = 3'(k);
    thresh = 7'(thr);
    for (int i = 0; i < w; i++) begin
      for (int g = 0; g < gap; g++) drive(1'b0, 4'd15);
      if (i < nurg) drive(1'b1, 4'(8 + (i % 8)));
      else          drive(1'b1, 4'(i % 8));
      if (i == w - 1) exp_flag = (nurg > thr);
      chk(req, congested, exp_flag);
    end
  endtask

  task automatic t_reset_state();
    chk("R7 flag low after reset", congested, 1'b0);
  endtask

  task automatic t_urgent_boundary();
    win_len_log2 = 3'd2;
    thresh = 7'd0;
    drive(1'b1, 4'd7); chk("R1 prio 7", congested, 1'b0);
    drive(1'b1, 4'd7); chk("R1 prio 7", congested, 1'b0);
    drive(1'b1, 4'd0); chk("R1 prio 0", congested, 1'b0);
    drive(1'b1, 4'd7); chk("R1 window of prio<=7 not congested", congested, 1'b0);
    exp_flag = 1'b0;
    drive(1'b1, 4'd8); chk("R1 hold", congested, 1'b0);
    drive(1'b1, 4'd3); chk("R1 hold", congested, 1'b0);
    drive(1'b1, 4'd3); chk("R1 hold", congested, 1'b0);
    drive(1'b1, 4'd3); chk("R1 prio 8 is urgent", congested, 1'b1);
    exp_flag = 1'b1;
    run_window("R1 all low clears", 2, 0, 0, 0);
  endtask

  task automatic t_threshold_equal();
    run_window("R3 count equal to threshold", 3, 3, 3, 0);
    run_window("R3 count above threshold", 3, 3, 4, 0);
    run_window("R3 equal again clears", 3, 4, 4, 0);
  endtask

  task automatic t_idle_cycles();
    run_window("R5 idle cycles ignored", 2, 1, 2, 3);
    run_window("R5 idle cycles ignored", 2, 1, 1, 2);
  endtask

  task automatic t_window_lengths();
    run_window("R2 clamp to 64", 7, 10, 11, 0);
    run_window("R2 64 below threshold", 6, 10, 10, 0);
    run_window("R2 single-request window", 0, 0, 1, 0);
    run_window("R2 single-request window", 0, 0, 0, 0);
  endtask

  task automatic t_full_threshold();
    run_window("R8 threshold equals window", 2, 4, 4, 0);
    run_window("R8 threshold zero", 2, 0, 1, 0);
  endtask

  task automatic t_sampling();
    run_window("R6 prep", 2, 0, 0, 0);
    win_len_log2 = 3'd2;
    thresh = 7'd5;
    drive(1'b1, 4'd12); chk("R6 first request", congested, 1'b0);
    win_len_log2 = 3'd5;
    drive(1'b1, 4'd1); chk("R6 length latched", congested, 1'b0);
    drive(1'b1, 4'd1); chk("R6 length latched", congested, 1'b0);
    thresh = 7'd0;
    drive(1'b1, 4'd1); chk("R6 closes after 4 using final threshold", congested, 1'b1);
    exp_flag = 1'b1;
  endtask

  task automatic t_mid_reset();
    run_window("R7 prep set", 2, 0, 2, 0);
    win_len_log2 = 3'd2;
    thresh = 7'd1;
    drive(1'b1, 4'd9);
    drive(1'b1, 4'd9);
    drive(1'b1, 4'd9);
    do_reset();
    chk("R7 flag cleared", congested, 1'b0);
    run_window("R7 counters emptied", 2, 1, 1, 0);
  endtask

  initial begin
    vectors = 0;
    miscompares = 0;
    done = 1'b0;
    exp_flag = 1'b0;
    req_valid = 1'b0;
    req_prio = 4'd0;
    win_len_log2 = 3'd2;
    thresh = 7'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_urgent_boundary();
    t_threshold_equal();
    t_idle_cycles();
    t_window_lengths();
    t_full_threshold();
    t_sampling();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule